// File: doc/BRIEF.md
# Isochronous Byte-Stream Port Controller

This block manages the handshake between an external 8-bit isochronous byte stream and an on-chip packet FIFO. All of its logic runs on the stream clock. The external side sees a direction input, an active-low byte-valid strobe, a byte bus that is split into input, output and output-enable, and an active-low access window. It also sees an error flag that travels with the window. On the core side the block raises write and read strobes and a one-cycle clear pulse. From the FIFO it takes four status bits: room for one whole packet, one complete packet ready, that packet's error flag, and a general access enable.

Transfers are counted in whole source packets of a fixed length set by a parameter. In transmit mode the window opens when the FIFO can take a complete packet. In receive mode it opens when a complete packet is waiting. A byte moves on each clock while the window is open and the valid strobe is low. The valid strobe can be released in the middle of a packet to pause the transfer. Between windows there is a minimum closed gap.

There are two release policies. In the first, the window closes after every packet. In the second, the window stays open across packet boundaries while access remains possible. A direction change clears the FIFO. A change from transmit to receive is held back until the packet in flight is complete.

Top module: `iso_stream_port`

## Requirements
- R1: While reset is high and right after it is released, the access window is closed (`win_n_o`=1), the bus is not driven, `err_o`=0, `fifo_clr_o`=0 and no read or write strobe is raised. The port starts in receive mode.
- R2: On the first rising edge that sees `dir_i` differ from the current mode (0 = transmit, 1 = receive), the mode switches. `fifo_clr_o` is high for exactly the one cycle after that edge.
- R3: In transmit mode the window opens when `room_i` and `access_en_i` are both high and the minimum gap has passed. Each clock with the window open and `valid_n_i`=0 raises `fifo_wr_o`, with `fifo_wdata_o` equal to `data_i`.
- R4: In receive mode the window opens when `pkt_rdy_i` and `access_en_i` are both high. Each clock with the window open and `valid_n_i`=0 pops one byte. The byte at the FIFO head is driven on `data_o` with `data_oe_o`=1 from the falling edge before the pop. Otherwise `data_oe_o`=0.
- R5: With `hold_mode_i`=0, the window closes on the edge that moves the last byte of a packet of PKT_LEN bytes.
- R6: With `hold_mode_i`=1, the window stays open across a packet boundary while access and FIFO availability hold. It closes on the first edge at which the window is open, no packet is partly moved and `access_en_i` is low.
- R7: Once closed, the window stays closed for at least MIN_GAP (default 2) clock periods.
- R8: While `valid_n_i` is high inside a window, no byte moves and the packet count holds. The transfer resumes when the strobe returns low, and the window closes only after PKT_LEN bytes in total.
- R9: In receive mode `err_o` rises together with the window opening when `pkt_err_i` is high at that edge, and falls when the window closes. If `pkt_err_i` is low, `err_o` stays 0.
- R10: If `dir_i` goes high while a transmit packet is partly moved, the port stays in transmit mode and keeps accepting bytes. The switch to receive mode and its clear pulse follow on the edge after the packet's last byte.
- R11: In transmit mode the bus is never driven (`data_oe_o`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Stream clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_i | input | 1 | Requested direction, 0 transmit, 1 receive |
| valid_n_i | input | 1 | Active-low byte-valid strobe |
| data_i | input | 8 | Byte bus, input side |
| data_o | output | 8 | Byte bus, output side |
| data_oe_o | output | 1 | Byte bus drive enable |
| win_n_o | output | 1 | Active-low access window |
| err_o | output | 1 | Received packet carries an error |
| hold_mode_i | input | 1 | Release policy, 0 per packet, 1 hold open |
| access_en_i | input | 1 | FIFO access permitted |
| room_i | input | 1 | FIFO can take a whole packet |
| pkt_rdy_i | input | 1 | A complete received packet is waiting |
| pkt_err_i | input | 1 | Error flag of the waiting packet |
| fifo_clr_o | output | 1 | One-cycle FIFO clear |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 8 | FIFO write byte |
| fifo_rd_o | output | 1 | FIFO read (pop) strobe |
| fifo_rdata_i | input | 8 | FIFO head byte |

## Verification
Several properties are checked on every cycle by the assertions. The window stays closed for at least two periods once it closes. The error flag appears only while the window is open. The per-packet policy closes the window after a packet's last byte. The bus is never driven in transmit mode. The byte count stays below the packet length. A partly moved transmit packet pins the mode. Other behaviours can only be shown by the bench's scenarios: the exact cycle of the clear pulse, the byte order and values on the bus, pauses of the valid strobe, the deferred direction switch, and the hold-open policy closing on loss of access.

// File: rtl/iso_port_pkg.sv
package iso_port_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef enum logic {
        WIN_GAP  = 1'b0,
        WIN_OPEN = 1'b1
    } win_e;

    typedef struct packed {
        logic access_en;
        logic room;
        logic pkt_rdy;
        logic pkt_err;
    } fifo_stat_t;

    function automatic logic can_move(dir_e m, fifo_stat_t s);
        return s.access_en && ((m == DIR_TX) ? s.room : s.pkt_rdy);
    endfunction

endpackage

// File: rtl/iso_dir_ctrl.sv
module iso_dir_ctrl
    import iso_port_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic dir_i,
    input  logic busy_i,
    output dir_e mode_o,
    output logic sw_o,
    output logic clr_o
);
    dir_e mode_q;
    logic clr_q;

    assign sw_o   = (dir_e'(dir_i) != mode_q) && !((mode_q == DIR_TX) && busy_i);
    assign mode_o = mode_q;
    assign clr_o  = clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= DIR_RX;
            clr_q  <= 1'b0;
        end else begin
            clr_q <= sw_o;
            if (sw_o) mode_q <= dir_e'(dir_i);
        end
    end

    // R10
    defer_tx_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == DIR_TX && busy_i) |=> (mode_q == DIR_TX));

endmodule

// File: rtl/iso_pkt_counter.sv
module iso_pkt_counter #(
    parameter int PKT_LEN = 188
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic step_i,
    output logic busy_o,
    output logic last_o
);
    localparam int CW = (PKT_LEN > 2) ? $clog2(PKT_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(PKT_LEN - 1);

    logic [CW-1:0] cnt_q;

    assign busy_o = (cnt_q != '0);
    assign last_o = step_i && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        int'(cnt_q) < PKT_LEN);

endmodule

// File: rtl/iso_win_ctrl.sv
module iso_win_ctrl
    import iso_port_pkg::*;
#(
    parameter int MIN_GAP = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sw_i,
    input  dir_e       mode_i,
    input  fifo_stat_t stat_i,
    input  logic       hold_mode_i,
    input  logic       pkt_done_i,
    input  logic       busy_i,
    input  logic       xfer_i,
    output logic       open_o,
    output logic       win_n_o,
    output logic       err_o
);
    localparam int GW = $clog2(MIN_GAP + 1);
    localparam logic [GW-1:0] GAP_LAST = GW'(MIN_GAP - 1);

    win_e          st_q;
    logic [GW-1:0] gap_q;
    logic          err_q;
    logic          ok;
    logic          rx_err;

    assign ok      = can_move(mode_i, stat_i);
    assign rx_err  = (mode_i == DIR_RX) && stat_i.pkt_err;
    assign open_o  = (st_q == WIN_OPEN);
    assign win_n_o = (st_q != WIN_OPEN);
    assign err_o   = err_q;

    always_ff @(posedge clk) begin
        if (rst || sw_i) begin
            st_q  <= WIN_GAP;
            gap_q <= '0;
            err_q <= 1'b0;
        end else begin
            case (st_q)
                WIN_GAP: begin
                    if (gap_q >= GAP_LAST && ok) begin
                        st_q  <= WIN_OPEN;
                        err_q <= rx_err;
                    end else if (gap_q < GAP_LAST) begin
                        gap_q <= gap_q + GW'(1);
                    end
                end
                WIN_OPEN: begin
                    if (pkt_done_i) begin
                        if (!hold_mode_i || !ok) begin
                            st_q  <= WIN_GAP;
                            gap_q <= '0;
                            err_q <= 1'b0;
                        end else begin
                            err_q <= rx_err;
                        end
                    end else if (hold_mode_i && !busy_i && !xfer_i && !stat_i.access_en) begin
                        st_q  <= WIN_GAP;
                        gap_q <= '0;
                        err_q <= 1'b0;
                    end
                end
                default: st_q <= WIN_GAP;
            endcase
        end
    end

    // R7
    min_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(win_n_o) |=> win_n_o);

    // R9
    err_in_win_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> !win_n_o);

    // R5
    negate_close_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold_mode_i && pkt_done_i) |=> win_n_o);

endmodule

// File: rtl/iso_rx_drive.sv
module iso_rx_drive
    import iso_port_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  dir_e          mode_i,
    input  logic          open_i,
    input  logic          valid_n_i,
    input  logic [DW-1:0] rdata_i,
    output logic [DW-1:0] data_o,
    output logic          oe_o
);
    logic          oe_q;
    logic [DW-1:0] data_q;
    logic          drive;

    assign drive  = (mode_i == DIR_RX) && open_i && !valid_n_i;
    assign oe_o   = oe_q;
    assign data_o = data_q;

    always_ff @(negedge clk) begin
        if (rst) begin
            oe_q   <= 1'b0;
            data_q <= '0;
        end else begin
            oe_q <= drive;
            if (drive) data_q <= rdata_i;
        end
    end

    // R11
    no_tx_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_i == DIR_TX) |-> !oe_q);

endmodule

// File: rtl/iso_stream_port.sv
module iso_stream_port
    import iso_port_pkg::*;
#(
    parameter int PKT_LEN = 188,
    parameter int MIN_GAP = 2,
    parameter int DW      = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dir_i,
    input  logic          valid_n_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o,
    output logic          data_oe_o,
    output logic          win_n_o,
    output logic          err_o,
    input  logic          hold_mode_i,
    input  logic          access_en_i,
    input  logic          room_i,
    input  logic          pkt_rdy_i,
    input  logic          pkt_err_i,
    output logic          fifo_clr_o,
    output logic          fifo_wr_o,
    output logic [DW-1:0] fifo_wdata_o,
    output logic          fifo_rd_o,
    input  logic [DW-1:0] fifo_rdata_i
);
    dir_e       mode;
    fifo_stat_t stat;
    logic       sw, busy, last, open, xfer;

    assign stat = '{access_en: access_en_i, room: room_i,
                    pkt_rdy: pkt_rdy_i, pkt_err: pkt_err_i};
    assign xfer = open && !valid_n_i && !sw;

    assign fifo_wr_o    = xfer && (mode == DIR_TX);
    assign fifo_rd_o    = xfer && (mode == DIR_RX);
    assign fifo_wdata_o = data_i;

    iso_dir_ctrl u_dir (
        .clk    (clk),
        .rst    (rst),
        .dir_i  (dir_i),
        .busy_i (busy),
        .mode_o (mode),
        .sw_o   (sw),
        .clr_o  (fifo_clr_o)
    );

    iso_pkt_counter #(.PKT_LEN(PKT_LEN)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (sw),
        .step_i (xfer),
        .busy_o (busy),
        .last_o (last)
    );

    iso_win_ctrl #(.MIN_GAP(MIN_GAP)) u_win (
        .clk         (clk),
        .rst         (rst),
        .sw_i        (sw),
        .mode_i      (mode),
        .stat_i      (stat),
        .hold_mode_i (hold_mode_i),
        .pkt_done_i  (last),
        .busy_i      (busy),
        .xfer_i      (xfer),
        .open_o      (open),
        .win_n_o     (win_n_o),
        .err_o       (err_o)
    );

    iso_rx_drive #(.DW(DW)) u_drv (
        .clk       (clk),
        .rst       (rst),
        .mode_i    (mode),
        .open_i    (open),
        .valid_n_i (valid_n_i),
        .rdata_i   (fifo_rdata_i),
        .data_o    (data_o),
        .oe_o      (data_oe_o)
    );

endmodule

// File: tb/iso_stream_port_tb.sv
`timescale 1ns/1ps
module iso_stream_port_tb;
    localparam int PL = 6;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       dir = 1'b1, valid_n = 1'b1, hold = 1'b0, acc = 1'b1;
    logic       room = 1'b0, rdy = 1'b0, perr = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, wdata, rdata;
    logic       oe, win_n, err, clr, wr, rd;
    int         pops = 0;
    int         nchk = 0, nfail = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    always @(posedge clk) if (rd) pops <= pops + 1;
    assign rdata = 8'hA0 + pops[7:0];

    iso_stream_port #(.PKT_LEN(PL), .MIN_GAP(2), .DW(8)) u_dut (
        .clk(clk), .rst(rst), .dir_i(dir), .valid_n_i(valid_n), .data_i(din),
        .data_o(dout), .data_oe_o(oe), .win_n_o(win_n), .err_o(err),
        .hold_mode_i(hold), .access_en_i(acc), .room_i(room), .pkt_rdy_i(rdy),
        .pkt_err_i(perr), .fifo_clr_o(clr), .fifo_wr_o(wr), .fifo_wdata_o(wdata),
        .fifo_rd_o(rd), .fifo_rdata_i(rdata)
    );

    task automatic chk(string req, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #3;
    endtask

    task automatic smp();
        #10;
    endtask

    task automatic wait_open(string req);
        for (int i = 0; i < 20; i++) begin
            cyc(); smp();
            if (!win_n) break;
        end
        chk(req, win_n, 0);
    endtask

    task automatic t_reset();
        repeat (3) cyc();
        smp();
        chk("R1 win in reset", win_n, 1);
        chk("R1 oe in reset", oe, 0);
        cyc(); rst = 1'b0; smp();
        chk("R1 win after reset", win_n, 1);
        chk("R1 err/clr/strobes", {err, clr, wr, rd}, 0);
    endtask

    task automatic t_rx_negate();
        int hi;
        rdy = 1'b1; perr = 1'b1;
        wait_open("R4 rx window opens");
        chk("R9 err with window", err, 1);
        chk("R4 bus idle without valid", oe, 0);
        for (int i = 0; i < PL; i++) begin
            cyc(); valid_n = 1'b0; smp();
            chk("R4 drive enable", oe, 1);
            chk("R4 byte order", dout, 8'hA0 + i);
        end
        cyc(); valid_n = 1'b1; perr = 1'b0; smp();
        chk("R5 rx close after packet", win_n, 1);
        chk("R9 err released with window", err, 0);
        chk("R4 bus released", oe, 0);
        chk("R4 pop count", pops, PL);
        hi = 1;
        for (int i = 0; i < 10; i++) begin
            cyc(); smp();
            if (!win_n) break;
            hi++;
        end
        chk("R7 gap length", hi, 2);
        chk("R9 no err for clean packet", err, 0);
        rdy = 1'b0;
    endtask

    task automatic t_tx_switch();
        room = 1'b1;
        cyc(); dir = 1'b0; smp();
        cyc(); smp();
        chk("R2 clear pulse", clr, 1);
        cyc(); smp();
        chk("R2 clear one cycle", clr, 0);
        cyc(); smp();
        chk("R3 tx window opens", win_n, 0);
        for (int i = 0; i < PL; i++) begin
            cyc(); valid_n = 1'b0; din = 8'h10 + i[7:0]; smp();
            chk("R3 write strobe", wr, 1);
            chk("R3 write data", wdata, 8'h10 + i);
            chk("R11 no drive in tx", oe, 0);
        end
        cyc(); valid_n = 1'b1; smp();
        chk("R5 tx close after packet", win_n, 1);
    endtask

    task automatic t_pause();
        int n = 0;
        wait_open("R8 window for pause");
        for (int i = 0; i < 3; i++) begin
            cyc(); valid_n = 1'b0; smp(); n += int'(wr);
        end
        for (int i = 0; i < 2; i++) begin
            cyc(); valid_n = 1'b1; smp();
            chk("R8 no write while paused", wr, 0);
            chk("R8 window held", win_n, 0);
        end
        for (int i = 0; i < 3; i++) begin
            cyc(); valid_n = 1'b0; smp(); n += int'(wr);
        end
        cyc(); valid_n = 1'b1; smp();
        chk("R8 bytes moved", n, PL);
        chk("R8 close after full packet", win_n, 1);
    endtask

    task automatic t_defer();
        wait_open("R10 window");
        for (int i = 0; i < 3; i++) begin
            cyc(); valid_n = 1'b0; smp();
        end
        cyc(); valid_n = 1'b1; dir = 1'b1; smp();
        cyc(); smp();
        chk("R10 no clear mid packet", clr, 0);
        for (int i = 0; i < 3; i++) begin
            cyc(); valid_n = 1'b0; smp();
            chk("R10 still accepting", wr, 1);
            chk("R10 still no clear", clr, 0);
        end
        cyc(); valid_n = 1'b1; smp();
        chk("R10 clear not yet", clr, 0);
        cyc(); smp();
        chk("R10 deferred clear", clr, 1);
    endtask

    task automatic t_assert_mode();
        hold = 1'b1;
        cyc(); dir = 1'b0; smp();
        wait_open("R6 window");
        for (int i = 0; i < PL; i++) begin
            cyc(); valid_n = 1'b0; smp();
        end
        cyc(); valid_n = 1'b1; smp();
        chk("R6 held open across boundary", win_n, 0);
        cyc(); acc = 1'b0; smp();
        chk("R6 open until edge", win_n, 0);
        cyc(); smp();
        chk("R6 closed on access loss", win_n, 1);
    endtask

    initial begin
        t_reset();
        t_rx_negate();
        t_tx_switch();
        t_pause();
        t_defer();
        t_assert_mode();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++; nfail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule